// File: doc/BRIEF.md
# Indexed Codec Register Access Port

This block gives a host a two-location window into the 32 byte-wide control registers of an audio codec. The first location is an index and control register. Its low five bits pick an internal register. Bit 5 selects whether a pending codec interrupt stops DMA transfers, and bit 6 enables mode changes. The second location is a data window that reads or writes whichever internal register the stored index points at. An external expanded-mode input decides whether the upper sixteen slots can be reached. When it is low, index bit 4 is dropped and those indices fold back onto slots 0 to 15.

After reset the codec goes through an initialization phase that lasts a fixed number of clocks. An external request can restart this phase at any time. While it lasts, host writes have no effect and both locations read back 0x80. When it ends, the index location shows 0x40.

The block drives a DMA transfer gate from the stop-on-interrupt bit and bit 0 of the codec status. Bus accesses take one cycle. Read data comes from a register and is updated on the clock after a read strobe.

Top module: `codec_index_port`

## Requirements
- R1: From reset release, for INIT_CYCLES clock edges, a read of either location returns 0x80. After that, with no host write, the index location reads 0x40.
- R2: A write to either location while the initialization phase is active changes no stored state.
- R3: A write to the index location (regSel=0) stores data bits 6:0. Bit 7 is read-only, and a read returns {0, stored bits 6:0}.
- R4: With expandEn=1, a data window access (regSel=1) reaches the slot whose number is index bits 4:0, from 0 to 31.
- R5: With expandEn=0, index bit 4 is ignored. Index 16+k reaches slot k.
- R6: Slots 13, 24, 25, 26, 27 and 29 always read 0x00 and ignore writes.
- R7: All other slots keep the last byte written to them and reset to 0x00. rdData resets to 0x00.
- R8: rdData takes the read value on the clock edge where rdStb is high and holds it until the next read. When a read and a write share a cycle, the read returns the value from before the write.
- R9: dmaEnable is 0 exactly when index bit 5 is 1 and irqPending is 1. Otherwise it is 1.
- R10: A pulse on initReq restarts the initialization phase for INIT_CYCLES edges. The index and slot contents are kept through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | 0 = index/control location, 1 = data window |
| rdStb | input | 1 | Read strobe, one access per high cycle |
| wrStb | input | 1 | Write strobe, one access per high cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| expandEn | input | 1 | Allows access to slots 16 to 31 |
| irqPending | input | 1 | Codec status bit 0 (interrupt pending) |
| initReq | input | 1 | Restarts the initialization phase |
| dmaEnable | output | 1 | DMA transfer gate |

## Verification
A behavioural model in the bench predicts rdData and dmaEnable every cycle, and both outputs are compared each clock.

The data window is exercised in three ways:
- A sweep over all 32 indices with distinct per-slot values. This separates true storage from reserved zero slots and exposes any address decode that drops or swaps a bit.
- The same indices with expanded mode off. This shows aliasing onto the lower half and proves that the upper slots stay unchanged.
- Writes and reads issued during initialization, both right after reset and after a mid-run restart. This shows the blocked writes and the fixed 0x80 value.

The irqPending input is toggled with the stop bit both set and clear, which separates the gated DMA case from the ungated one.

// File: rtl/codec_idx_pkg.sv
package codec_idx_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic idxWr;   // accepted write to index/control location
    logic datWr;   // accepted write to data window
    logic rdIdx;   // read of index location, not busy
    logic rdDat;   // read of data window, not busy
    logic rdBusy;  // read of either location during init
  } accStb_t;

  function automatic logic slotReserved(input int unsigned n);
    return (n == 13) || (n >= 24 && n <= 27) || (n == 29);
  endfunction

endpackage

// File: rtl/codec_idx_ctrl.sv
module codec_idx_ctrl
  import codec_idx_pkg::*;
#(
  parameter int INIT_CYCLES = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    regSel,
  input  logic    rdStb,
  input  logic    wrStb,
  input  logic    initReq,
  output accStb_t stb,
  output logic    initBusy
);

  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(INIT_CYCLES);

  logic [CW-1:0] initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= CNT_LOAD;
    end else if (initReq) begin
      initCnt <= CNT_LOAD;
    end else if (initCnt != '0) begin
      initCnt <= initCnt - 1'b1;
    end
  end

  assign initBusy = (initCnt != '0);

  always_comb begin
    stb.idxWr  = wrStb && !regSel && !initBusy;
    stb.datWr  = wrStb &&  regSel && !initBusy;
    stb.rdIdx  = rdStb && !regSel && !initBusy;
    stb.rdDat  = rdStb &&  regSel && !initBusy;
    stb.rdBusy = rdStb && initBusy;
  end

  // R10
  reinit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initReq) |-> initBusy);

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdIdx, stb.rdDat, stb.rdBusy}));

  // R2
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!initBusy && !initReq) |=> !initBusy);

endmodule

// File: rtl/codec_idx_dp.sv
module codec_idx_dp
  import codec_idx_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  accStb_t       stb,
  input  logic [DW-1:0] wrData,
  input  logic          expandEn,
  output logic          dmaStop,
  output logic [DW-1:0] rdData
);

  localparam int AW       = $clog2(NUM_REGS);
  localparam int CTRL_W   = 7;
  localparam logic [CTRL_W-1:0] IDX_RST = 7'h40;
  localparam logic [DW-1:0] BUSY_VAL = DW'(8'h80);

  logic [CTRL_W-1:0]  idxReg;
  logic [AW-1:0]      slotSel;
  logic [DW-1:0]      slotQ [NUM_REGS];
  logic [NUM_REGS-1:0] resMask;

  // index/control register: bit 6 mode change, bit 5 dma stop, low bits index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idxReg <= IDX_RST;
    else if (stb.idxWr) idxReg <= wrData[CTRL_W-1:0];
  end

  assign dmaStop = idxReg[5];

  // upper half folds onto lower half unless expanded mode is on
  assign slotSel = expandEn ? idxReg[AW-1:0] : {1'b0, idxReg[AW-2:0]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (slotReserved(g)) begin : gRes
      assign slotQ[g]   = '0;
      assign resMask[g] = 1'b1;
    end else begin : gStore
      assign resMask[g] = 1'b0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  slotQ[g] <= '0;
        else if (stb.datWr && slotSel == AW'(g))    slotQ[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdBusy) rdData <= BUSY_VAL;
    else if (stb.rdIdx)  rdData <= DW'({1'b0, idxReg});
    else if (stb.rdDat)  rdData <= slotQ[slotSel];
  end

  // R1
  busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.rdBusy) |-> rdData == BUSY_VAL);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.rdBusy || stb.rdIdx || stb.rdDat) |-> $stable(rdData));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.idxWr) |-> $stable(idxReg));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.rdDat) && $past(resMask[slotSel])) |-> rdData == '0);

endmodule

// File: rtl/codec_index_port.sv
module codec_index_port
  import codec_idx_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int NUM_REGS    = 32,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regSel,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          expandEn,
  input  logic          irqPending,
  input  logic          initReq,
  output logic          dmaEnable
);

  accStb_t stb;
  logic    initBusy;
  logic    dmaStop;

  codec_idx_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .initReq  (initReq),
    .stb      (stb),
    .initBusy (initBusy)
  );

  codec_idx_dp #(.NUM_REGS(NUM_REGS), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .expandEn (expandEn),
    .dmaStop  (dmaStop),
    .rdData   (rdData)
  );

  assign dmaEnable = !(dmaStop && irqPending);

  // R9
  dma_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> dmaEnable);

endmodule

// File: tb/codec_index_port_bench.sv
module codec_index_port_bench;

  localparam int INIT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       expandEn = 1'b0, irqPending = 1'b0, initReq = 1'b0;
  logic       dmaEnable;

  int checks = 0;
  int fails  = 0;
  string phase = "R7 reset";

  // reference model state
  logic [7:0] mSlot [32];
  logic [6:0] mIdx;
  int         mCnt;
  logic [7:0] mRd;

  always #2 clk = ~clk;

  codec_index_port #(.INIT_CYCLES(INIT)) u_codec_index_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .expandEn(expandEn),
    .irqPending(irqPending), .initReq(initReq), .dmaEnable(dmaEnable)
  );

  function automatic bit isRes(int n);
    return n == 13 || (n >= 24 && n <= 27) || n == 29;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) mSlot[i] = 8'h00;
    mIdx = 7'h40; mCnt = INIT; mRd = 8'h00;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mSlot[i] = 8'h00;
      mIdx = 7'h40; mCnt = INIT; mRd = 8'h00;
    end else begin
      bit busy;
      int slot;
      busy = (mCnt != 0);
      slot = expandEn ? int'(mIdx[4:0]) : int'(mIdx[3:0]);
      if (rdStb) begin
        if (busy)        mRd = 8'h80;
        else if (!regSel) mRd = {1'b0, mIdx};
        else             mRd = isRes(slot) ? 8'h00 : mSlot[slot];
      end
      if (wrStb && !busy) begin
        if (!regSel)           mIdx = wrData[6:0];
        else if (!isRes(slot)) mSlot[slot] = wrData;
      end
      if (initReq)       mCnt = INIT;
      else if (mCnt > 0) mCnt = mCnt - 1;
    end
  end

  task automatic compareNow();
    logic expDma;
    expDma = !(mIdx[5] && irqPending);
    checks++;
    if (rdData !== mRd) begin
      fails++;
      $display("FAIL %s rdData got %h exp %h", phase, rdData, mRd);
    end
    checks++;
    if (dmaEnable !== expDma) begin
      fails++;
      $display("FAIL %s (R9) dmaEnable got %b exp %b", phase, dmaEnable, expDma);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compareNow();
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] d);
    regSel = sel; wrData = d; wrStb = 1'b1;
    cyc();
    wrStb = 1'b0;
  endtask

  task automatic busRead(input logic sel);
    regSel = sel; rdStb = 1'b1;
    cyc();
    rdStb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired in %s", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    phase = "R7 reset";
    idle(3);
    rstN = 1'b1;

    phase = "R1 init read";
    busRead(1'b0);
    busRead(1'b1);
    phase = "R2 init write";
    busWrite(1'b0, 8'h25);
    busWrite(1'b1, 8'hAA);
    idle(INIT);
    phase = "R1 post-init index";
    busRead(1'b0);
    phase = "R2 slot0 untouched";
    busRead(1'b1);

    phase = "R3 index bit7 read-only";
    busWrite(1'b0, 8'hFF);
    busRead(1'b0);
    busWrite(1'b0, 8'h80);
    busRead(1'b0);

    phase = "R4 R6 R7 sweep write";
    expandEn = 1'b1;
    for (int i = 0; i < 32; i++) begin
      busWrite(1'b0, 8'(i));
      busWrite(1'b1, 8'(i * 7 + 3));
    end
    phase = "R4 R6 R7 sweep read";
    for (int i = 31; i >= 0; i--) begin
      busWrite(1'b0, 8'(i));
      busRead(1'b1);
    end

    phase = "R5 alias";
    expandEn = 1'b0;
    busWrite(1'b0, 8'h13);
    busRead(1'b1);
    busWrite(1'b1, 8'h5C);
    busRead(1'b1);
    busWrite(1'b0, 8'h1D);
    busRead(1'b1);
    busWrite(1'b1, 8'hEE);
    busRead(1'b1);
    expandEn = 1'b1;
    busWrite(1'b0, 8'h13);
    busRead(1'b1);
    busWrite(1'b0, 8'h03);
    busRead(1'b1);

    phase = "R8 read during write";
    regSel = 1'b1; wrData = 8'h77; wrStb = 1'b1; rdStb = 1'b1;
    cyc();
    wrStb = 1'b0; rdStb = 1'b0;
    phase = "R8 hold";
    idle(3);
    busRead(1'b1);

    phase = "R9 dma gate";
    irqPending = 1'b1; cyc();
    busWrite(1'b0, 8'h20);
    irqPending = 1'b0; cyc();
    irqPending = 1'b1; cyc();
    busWrite(1'b0, 8'h00);
    irqPending = 1'b0; cyc();

    phase = "R10 reinit";
    busWrite(1'b0, 8'h65);
    busWrite(1'b1, 8'h42);
    initReq = 1'b1; cyc(); initReq = 1'b0;
    busRead(1'b0);
    busWrite(1'b1, 8'h11);
    busRead(1'b1);
    irqPending = 1'b1; cyc(); irqPending = 1'b0;
    idle(INIT);
    busRead(1'b0);
    busRead(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule